// File: doc/BRIEF.md
# Card Data Word Packer with Transfer Countdown

This block connects a 32-bit register data port to a byte-wide card data stream. A word FIFO sits between the two sides. When a read transfer is active, bytes arriving from the card are assembled into words, least significant byte first, and pushed into the FIFO. Software then drains the FIFO through the data register. When a write transfer is active, software fills the FIFO through the same register, and the block pops words and sends their bytes to the card, low byte first.

A byte countdown decides how long a transfer runs. Writing the block-count register loads it with the block count times the block byte size. Each byte that moves decrements it, and the transfer stops when it reaches zero. Word moves set a data flag and, if enabled, a data interrupt. On writes, the end of each block raises a block interrupt. A debug register shows the live FIFO fill level and a state code that goes to "data mode" (1) when the countdown ends.

Top module: `sd_data_packer`

## Requirements
- R1: After reset, the debug register (offset 0x34) reads 0x0000C60F, the status register (offset 0x20) reads 0, and irq_o is low.
- R2: A write to the debug register stores bits 31:9 and bits 3:0 as written, except that a low nibble of 0xF is stored as 0x0. Bits 8:4 always read back the FIFO level.
- R3: The FIFO holds DEPTH words of 32 bits in first-in first-out order. A push while it is full is dropped. A read of the data register (offset 0x40) while it is empty returns 0 and leaves the level at 0.
- R4: Writing the block-count register (offset 0x50, low BLKS_W bits) loads the byte countdown with that value times the block size register (offset 0x3C, low SIZE_W bits). Exactly that many bytes then move before the card handshake goes idle.
- R5: In read mode (mode register offset 0x00, bit 6), received card bytes fill bits 7:0, 15:8, 23:16 and 31:24 of a word in arrival order. A word is pushed after its fourth byte.
- R6: In read mode, when the countdown reaches zero partway through a word, that word is pushed with its unfilled upper bytes at zero.
- R7: In read mode, rx_ready_o is low while the FIFO is full, so no card byte is accepted until a word has been popped.
- R8: In write mode (mode register bit 7), each popped word is sent as four bytes, low byte first. Sending stops when the countdown reaches zero, and the unsent bytes of that word are discarded. No further word is popped.
- R9: Each word that the packer pushes or the unpacker pops sets status bit 0 (data flag). It also sets status bit 8 when config register (offset 0x38) bit 4 is 1.
- R10: In write mode, each byte that ends a block (the remaining count becomes a multiple of the block size) sets status bit 9 when config bit 8 is 1. With config bit 8 at 0, bit 9 stays 0.
- R11: When the countdown reaches zero through a byte transfer, debug bits 3:0 become 0x1.
- R12: Debug bits 8:4 report the current FIFO level, from 0 to DEPTH.
- R13: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. irq_o is high exactly when status bit 8 or bit 9 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the FIFO at the data offset) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| rx_valid_i | input | 1 | Card byte available |
| rx_data_i | input | 8 | Card byte received |
| rx_ready_o | output | 1 | Block accepts a card byte |
| tx_valid_o | output | 1 | Byte to the card is available |
| tx_data_o | output | 8 | Byte sent to the card |
| tx_ready_i | input | 1 | Card accepts the byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 16 FIFO words, a 16-bit block size and a 9-bit block count. With these, a directed 70-byte read overruns the 64-byte FIFO capacity, so the full-FIFO stall and the later resume are both exercised. Random block sizes from 1 to 12 produce word-partial tails and several block boundaries per transfer. These expose the flush of a partial word, the mid-word stop on writes and the block interrupt. Random handshake gaps on both card directions shift where word boundaries fall relative to register accesses.

// File: rtl/sd_pk_pkg.sv
package sd_pk_pkg;
  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h20;
  localparam logic [7:0] OFS_DBG   = 8'h34;
  localparam logic [7:0] OFS_CFG   = 8'h38;
  localparam logic [7:0] OFS_BSIZE = 8'h3C;
  localparam logic [7:0] OFS_DATA  = 8'h40;
  localparam logic [7:0] OFS_BCNT  = 8'h50;

  localparam int MODE_RD     = 6;
  localparam int MODE_WR     = 7;
  localparam int ST_DATA     = 0;
  localparam int ST_DIRQ     = 8;
  localparam int ST_BIRQ     = 9;
  localparam int CFG_DIRQ_EN = 4;
  localparam int CFG_BIRQ_EN = 8;

  localparam logic [31:0] DBG_RST      = 32'h0000_C60F;
  localparam logic [3:0]  DBG_ST_DATA  = 4'h1;
  localparam logic [3:0]  DBG_ST_PWRDN = 4'hF;
endpackage

// File: rtl/sd_pk_fifo.sv
module sd_pk_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];
  assign level_o = level_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      level_q <= level_q + 1'b1;
      else if (do_pop && !do_push) level_q <= level_q - 1'b1;
    end
  end
endmodule

// File: rtl/sd_pk_rx_pack.sv
module sd_pk_rx_pack #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          last_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          take_o,
  output logic          push_o,
  output logic [DW-1:0] word_o
);
  localparam int BPW = DW / 8;
  localparam int IW  = (BPW > 1) ? $clog2(BPW) : 1;

  logic [DW-1:0] acc_q;
  logic [IW-1:0] idx_q;
  logic          word_full;

  assign rx_ready_o = en_i;
  assign take_o     = en_i && rx_valid_i;
  assign word_full  = (idx_q == IW'(BPW-1));
  assign word_o     = acc_q | (DW'(rx_data_i) << {idx_q, 3'b000});
  assign push_o     = take_o && (word_full || last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take_o) begin
      if (push_o) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q <= word_o;
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_pk_tx_unpack.sv
module sd_pk_tx_unpack #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          last_i,
  input  logic          hold_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_word_i,
  input  logic          tx_ready_i,
  output logic          pop_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          send_o
);
  localparam int BPW = DW / 8;
  localparam int LW  = $clog2(BPW+1);

  logic [DW-1:0] word_q;
  logic [LW-1:0] left_q;

  assign pop_o      = active_i && (left_q == '0) && !fifo_empty_i && !hold_i;
  assign tx_valid_o = active_i && (left_q != '0);
  assign tx_data_o  = word_q[7:0];
  assign send_o     = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      left_q <= '0;
    end else if (pop_o) begin
      word_q <= fifo_word_i;
      left_q <= LW'(BPW);
    end else if (send_o) begin
      word_q <= word_q >> 8;
      left_q <= last_i ? '0 : left_q - 1'b1;   // drop tail of word at count end
    end
  end
endmodule

// File: rtl/sd_data_packer.sv
module sd_data_packer
  import sd_pk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 16,
  parameter int BLKS_W = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  output logic        irq_o
);
  localparam int DW    = 32;
  localparam int CNT_W = SIZE_W + BLKS_W;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic              mode_rd_q, mode_wr_q;
  logic              cfg_dirq_q, cfg_birq_q;
  logic              st_data_q, st_dirq_q, st_birq_q;
  logic [31:9]       dbg_hi_q;
  logic [3:0]        dbg_st_q;
  logic [SIZE_W-1:0] bsize_q, blk_left_q;
  logic [BLKS_W-1:0] bcnt_q;
  logic [CNT_W-1:0]  cnt_q;

  logic we_mode, we_stat, we_dbg, we_cfg, we_bsize, we_bcnt;
  logic reg_push, reg_pop;
  logic cnt_zero, cnt_last, byte_step, blk_done, xfer_word;

  logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0]    fifo_wdata, fifo_rdata;
  logic [LVL_W-1:0] fifo_level;

  logic          rx_en, rx_take, rx_push;
  logic [DW-1:0] rx_word;
  logic          tx_pop, tx_send;

  assign we_mode  = reg_we_i && (reg_addr_i == OFS_MODE);
  assign we_stat  = reg_we_i && (reg_addr_i == OFS_STAT);
  assign we_dbg   = reg_we_i && (reg_addr_i == OFS_DBG);
  assign we_cfg   = reg_we_i && (reg_addr_i == OFS_CFG);
  assign we_bsize = reg_we_i && (reg_addr_i == OFS_BSIZE);
  assign we_bcnt  = reg_we_i && (reg_addr_i == OFS_BCNT);
  assign reg_push = reg_we_i && (reg_addr_i == OFS_DATA);
  assign reg_pop  = reg_re_i && (reg_addr_i == OFS_DATA);

  assign cnt_zero  = (cnt_q == '0);
  assign cnt_last  = (cnt_q == CNT_W'(1));
  assign byte_step = rx_take || tx_send;
  assign blk_done  = tx_send && (blk_left_q == SIZE_W'(1));
  assign xfer_word = rx_push || tx_pop;

  // register-side push owns the single FIFO write port
  assign rx_en      = mode_rd_q && !cnt_zero && !fifo_full && !reg_push;
  assign fifo_push  = reg_push || rx_push;
  assign fifo_wdata = reg_push ? reg_wdata_i : rx_word;
  assign fifo_pop   = reg_pop || tx_pop;

  sd_pk_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .level_o (fifo_level),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  sd_pk_rx_pack #(.DW(DW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en),
    .last_i     (cnt_last),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_ready_o (rx_ready_o),
    .take_o     (rx_take),
    .push_o     (rx_push),
    .word_o     (rx_word)
  );

  sd_pk_tx_unpack #(.DW(DW)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (mode_wr_q && !cnt_zero),
    .last_i       (cnt_last),
    .hold_i       (reg_pop),
    .fifo_empty_i (fifo_empty),
    .fifo_word_i  (fifo_rdata),
    .tx_ready_i   (tx_ready_i),
    .pop_o        (tx_pop),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o),
    .send_o       (tx_send)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_rd_q  <= 1'b0;
      mode_wr_q  <= 1'b0;
      cfg_dirq_q <= 1'b0;
      cfg_birq_q <= 1'b0;
      bsize_q    <= '0;
      bcnt_q     <= '0;
    end else begin
      if (we_mode) begin
        mode_rd_q <= reg_wdata_i[MODE_RD];
        mode_wr_q <= reg_wdata_i[MODE_WR];
      end
      if (we_cfg) begin
        cfg_dirq_q <= reg_wdata_i[CFG_DIRQ_EN];
        cfg_birq_q <= reg_wdata_i[CFG_BIRQ_EN];
      end
      if (we_bsize) bsize_q <= reg_wdata_i[SIZE_W-1:0];
      if (we_bcnt)  bcnt_q  <= reg_wdata_i[BLKS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      blk_left_q <= '0;
    end else begin
      if (we_bcnt) begin
        cnt_q      <= CNT_W'(reg_wdata_i[BLKS_W-1:0]) * CNT_W'(bsize_q);
        blk_left_q <= bsize_q;
      end else begin
        if (byte_step) cnt_q <= cnt_q - 1'b1;
        if (tx_send)   blk_left_q <= blk_done ? bsize_q : blk_left_q - 1'b1;
      end
    end
  end

  // status: set wins over write-one-to-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_data_q <= 1'b0;
      st_dirq_q <= 1'b0;
      st_birq_q <= 1'b0;
    end else begin
      if (we_stat) begin
        if (reg_wdata_i[ST_DATA]) st_data_q <= 1'b0;
        if (reg_wdata_i[ST_DIRQ]) st_dirq_q <= 1'b0;
        if (reg_wdata_i[ST_BIRQ]) st_birq_q <= 1'b0;
      end
      if (xfer_word) begin
        st_data_q <= 1'b1;
        if (cfg_dirq_q) st_dirq_q <= 1'b1;
      end
      if (blk_done && cfg_birq_q) st_birq_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_hi_q <= DBG_RST[31:9];
      dbg_st_q <= DBG_RST[3:0];
    end else begin
      if (we_dbg) begin
        dbg_hi_q <= reg_wdata_i[31:9];
        dbg_st_q <= (reg_wdata_i[3:0] == DBG_ST_PWRDN) ? 4'h0 : reg_wdata_i[3:0];
      end
      if (byte_step && cnt_last) dbg_st_q <= DBG_ST_DATA;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_MODE: begin
        reg_rdata_o[MODE_RD] = mode_rd_q;
        reg_rdata_o[MODE_WR] = mode_wr_q;
      end
      OFS_STAT: begin
        reg_rdata_o[ST_DATA] = st_data_q;
        reg_rdata_o[ST_DIRQ] = st_dirq_q;
        reg_rdata_o[ST_BIRQ] = st_birq_q;
      end
      OFS_DBG:   reg_rdata_o = {dbg_hi_q, 5'(fifo_level), dbg_st_q};
      OFS_CFG: begin
        reg_rdata_o[CFG_DIRQ_EN] = cfg_dirq_q;
        reg_rdata_o[CFG_BIRQ_EN] = cfg_birq_q;
      end
      OFS_BSIZE: reg_rdata_o = 32'(bsize_q);
      OFS_BCNT:  reg_rdata_o = 32'(bcnt_q);
      OFS_DATA:  reg_rdata_o = fifo_rdata;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = st_dirq_q || st_birq_q;
endmodule

// File: rtl/sd_data_packer_chk.sv
module sd_data_packer_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [$clog2(DEPTH+1)-1:0] level_i,
  input logic                       rx_valid_i,
  input logic                       rx_ready_i,
  input logic                       tx_valid_i,
  input logic                       tx_ready_i,
  input logic                       cnt_zero_i,
  input logic                       cnt_last_i,
  input logic                       xfer_word_i,
  input logic [3:0]                 dbg_st_i,
  input logic                       st_data_i,
  input logic                       st_dirq_i,
  input logic                       st_birq_i,
  input logic                       dirq_en_i,
  input logic                       birq_en_i
);
  p_level_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= DEPTH);

  p_stall_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_i) |-> (level_i < DEPTH));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_zero_i |-> (!tx_valid_i && !rx_ready_i));

  p_done_state_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((rx_valid_i && rx_ready_i) || (tx_valid_i && tx_ready_i)) && cnt_last_i)
      |=> (dbg_st_i == 4'h1));

  p_data_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_word_i |=> st_data_i);

  p_dirq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_dirq_i) |-> $past(dirq_en_i));

  p_birq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_birq_i) |-> $past(birq_en_i));
endmodule

bind sd_data_packer sd_data_packer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .level_i     (fifo_level),
  .rx_valid_i  (rx_valid_i),
  .rx_ready_i  (rx_ready_o),
  .tx_valid_i  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .cnt_zero_i  (cnt_zero),
  .cnt_last_i  (cnt_last),
  .xfer_word_i (xfer_word),
  .dbg_st_i    (dbg_st_q),
  .st_data_i   (st_data_q),
  .st_dirq_i   (st_dirq_q),
  .st_birq_i   (st_birq_q),
  .dirq_en_i   (cfg_dirq_q),
  .birq_en_i   (cfg_birq_q)
);

// File: tb/sd_data_packer_bench.sv
`timescale 1ns/1ps
module sd_data_packer_bench;
  localparam logic [7:0] A_MODE = 8'h00, A_STAT = 8'h20, A_DBG = 8'h34,
                         A_CFG = 8'h38, A_BSIZE = 8'h3C, A_DATA = 8'h40,
                         A_BCNT = 8'h50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        irq;

  int n_cmp = 0, n_bad = 0;

  logic [7:0]  rx_mem [256];
  int          rx_n = 0, rx_idx = 0;
  logic        rx_hs = 1'b0;
  logic [7:0]  tx_got [256];
  int          tx_cnt = 0;
  logic [31:0] wr_words [16];

  always #2 clk = ~clk;

  sd_data_packer u_sd_data_packer (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .irq_o(irq)
  );

  // card source
  always begin
    @(negedge clk);
    if (rx_hs) rx_idx = rx_idx + 1;
    rx_valid = (rx_idx < rx_n) && ($urandom_range(3) != 0);
    rx_data  = rx_mem[rx_idx % 256];
    #1;
    rx_hs = rx_valid && rx_ready;
  end

  // card sink
  always begin
    @(negedge clk);
    tx_ready = ($urandom_range(3) != 0);
    #1;
    if (tx_valid && tx_ready) begin
      tx_got[tx_cnt % 256] = tx_data;
      tx_cnt = tx_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  function automatic logic [31:0] f_dbg(input logic [31:0] v, input int lvl);
    return {v[31:9], 5'(lvl), (v[3:0] == 4'hF) ? 4'h0 : v[3:0]};
  endfunction

  function automatic logic [31:0] f_pack(input int w, input int n);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (w*4 + b < n) r[b*8 +: 8] = rx_mem[w*4 + b];
    return r;
  endfunction

  task automatic drain();
    logic [31:0] d;
    rd(A_DBG, d);
    for (int i = 0; i < int'(d[8:4]); i++) begin
      logic [31:0] x;
      rd(A_DATA, x);
    end
  endtask

  task automatic run_read(input int bsize, input int blks, input bit den,
                          input bit stall_chk);
    logic [31:0] d;
    int n, nw, got;
    n  = bsize * blks;
    nw = (n + 3) / 4;
    drain();
    wr(A_DBG, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_CFG, den ? 32'h10 : 32'h0);
    wr(A_MODE, 32'h40);
    wr(A_BSIZE, bsize);
    for (int i = 0; i < n; i++) rx_mem[i] = 8'($urandom);
    @(posedge clk); #1;
    rx_idx = 0; rx_hs = 1'b0; rx_n = n + 4;  // extra bytes must not be taken
    wr(A_BCNT, blks);
    if (stall_chk) begin
      repeat (300) @(posedge clk);
      rd(A_DBG, d);
      chk("R7 level at stall", 32'(d[8:4]), 32'd16);
      chk("R7 ready low when full", 32'(rx_ready), 32'd0);
      chk("R7 bytes taken at stall", rx_idx, 64);
    end
    got = 0;
    while (got < nw) begin
      rd(A_DBG, d);
      for (int i = 0; i < int'(d[8:4]) && got < nw; i++) begin
        logic [31:0] x;
        rd(A_DATA, x);
        chk((got == nw-1 && (n % 4) != 0) ? "R6 partial word" : "R5 packed word",
            x, f_pack(got, n));
        got++;
      end
    end
    repeat (20) @(posedge clk);
    chk("R4 bytes taken on read", rx_idx, n);
    rd(A_DBG, d);
    chk("R11 state after read", 32'(d[3:0]), 32'h1);
    chk("R12 level after drain", 32'(d[8:4]), 32'h0);
    rd(A_STAT, d);
    chk("R9 status after read", d, den ? 32'h101 : 32'h1);
    chk("R13 irq after read", 32'(irq), 32'(den));
    rx_n = 0;
  endtask

  task automatic run_write(input int bsize, input int blks, input int extra,
                           input bit den, input bit ben);
    logic [31:0] d;
    int n, nw, k;
    n  = bsize * blks;
    nw = (n + 3) / 4;
    drain();
    wr(A_DBG, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_CFG, (den ? 32'h10 : 32'h0) | (ben ? 32'h100 : 32'h0));
    wr(A_MODE, 32'h80);
    wr(A_BSIZE, bsize);
    for (int i = 0; i < nw + extra; i++) begin
      wr_words[i] = $urandom;
      wr(A_DATA, wr_words[i]);
    end
    tx_cnt = 0;
    wr(A_BCNT, blks);
    k = 0;
    while (tx_cnt < n && k < 2000) begin @(posedge clk); k++; end
    repeat (20) @(posedge clk);
    chk("R4 bytes sent on write", tx_cnt, n);
    for (int i = 0; i < n; i++)
      chk("R8 sent byte", tx_got[i], wr_words[i/4][(i%4)*8 +: 8]);
    rd(A_DBG, d);
    chk("R8 words left after stop", 32'(d[8:4]), extra);
    chk("R11 state after write", 32'(d[3:0]), 32'h1);
    rd(A_STAT, d);
    chk("R10 block irq", 32'(d[9]), 32'(ben));
    chk("R9 data flags after write", 32'(d[8:0]), den ? 32'h101 : 32'h1);
    chk("R13 irq after write", 32'(irq), 32'(den | ben));
    for (int i = 0; i < extra; i++) begin
      rd(A_DATA, d);
      chk("R3 leftover order", d, wr_words[nw + i]);
    end
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    logic [31:0] q [17];
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_DBG, d);  chk("R1 debug reset", d, 32'h0000_C60F);
    rd(A_STAT, d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R2 debug write
    wr(A_DBG, 32'h1234_560F);
    rd(A_DBG, d); chk("R2 low nibble F stored as 0", d, f_dbg(32'h1234_560F, 0));
    v = $urandom; v[3:0] = 4'h7;
    wr(A_DBG, v);
    rd(A_DBG, d); chk("R2 debug write kept", d, f_dbg(v, 0));

    // R3 / R12 FIFO in idle mode
    wr(A_MODE, 32'h0);
    for (int i = 0; i < 17; i++) begin
      q[i] = $urandom;
      wr(A_DATA, q[i]);
      if (i == 4) begin
        rd(A_DBG, d); chk("R12 level mirror", 32'(d[8:4]), 32'd5);
      end
    end
    rd(A_DBG, d); chk("R3 level full after 17 pushes", 32'(d[8:4]), 32'd16);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, d); chk("R3 fifo order", d, q[i]);
    end
    rd(A_DATA, d); chk("R3 empty pop returns zero", d, 32'h0);
    rd(A_DBG, d);  chk("R3 level stays zero", 32'(d[8:4]), 32'd0);
    rd(A_STAT, d); chk("R9 register access sets no flag", d, 32'h0);

    // directed read cases
    run_read(5, 1, 1'b1, 1'b0);     // partial tail (R6)
    run_read(35, 2, 1'b0, 1'b1);    // overrun FIFO (R7)
    for (int t = 0; t < 6; t++)
      run_read($urandom_range(12, 1), $urandom_range(3, 1), 1'($urandom), 1'b0);

    // directed write cases
    run_write(6, 1, 1, 1'b0, 1'b0); // mid-word stop, block irq off
    run_write(4, 3, 0, 1'b1, 1'b1);
    for (int t = 0; t < 6; t++)
      run_write($urandom_range(12, 1), $urandom_range(3, 1), $urandom_range(2, 0),
                1'($urandom), 1'($urandom));

    // R13 write-one-to-clear
    rd(A_STAT, v);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R13 zero write keeps status", d, v);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R13 clear data flag only", d, v & ~32'h1);
    wr(A_STAT, 32'h300);
    rd(A_STAT, d); chk("R13 clear irq bits", d, 32'h0);
    chk("R13 irq low after clear", 32'(irq), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule